// File: doc/BRIEF.md
# ADC Result Register Interface

This block keeps the most recent 10-bit analog conversion result and shows it to a processor as a pair of 8-bit readable bytes, a low byte and a high byte. A justification control chooses how the result is placed across the two bytes. With right justification the result sits at the bottom of the 16-bit pair. With left justification it sits at the top, so the high byte alone carries an 8-bit reading.

A conversion is reported by a one-cycle completion strobe together with its value. The stored value is copied bit for bit, so a signed (two's complement) differential result keeps its form. A read of the low byte holds the stored pair until the high byte is read. While it is held, a completing conversion is dropped, and the processor then sees two bytes of one sample. A read of the high byte alone never leaves the pair held.

Top module: `adc_result_regs`

## Requirements
- R1: After synchronous reset both byte outputs are zero, right justification is in force and the pair is not held, so the first conversion is accepted.
- R2: With the justification input at 0, the high byte is {6'b0, result[9:8]} and the low byte is result[7:0].
- R3: With the justification input at 1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R4: A completion strobe sampled at a clock edge while the pair is not held shows the new value on both byte outputs directly after that edge.
- R5: A low-byte read strobe holds the pair. Completion strobes that arrive after it are discarded and the previous value stays on the outputs until a high-byte read strobe.
- R6: A completion strobe in the same cycle as a low-byte read strobe is discarded.
- R7: A high-byte read strobe releases the hold, and a completion strobe in that same cycle is accepted.
- R8: A high-byte read without a preceding low-byte read leaves the pair free, so the next conversion is accepted.
- R9: The stored value equals the conversion value bit for bit, including the extreme two's complement codes 10'h200 and 10'h1FF and the all-ones code.
- R10: A change of the justification input re-lays out the held value one edge later, without changing the value, also while the pair is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_value | input | 10 | Result carried with conv_done |
| left_adj | input | 1 | 1 selects left justification, 0 selects right |
| rd_lo | input | 1 | Strobe: the processor reads the low byte |
| rd_hi | input | 1 | Strobe: the processor reads the high byte |
| data_lo | output | 8 | Registered low byte |
| data_hi | output | 8 | Registered high byte |

## Verification
Directed patterns come first. Values with distinct bits in the positions that cross the byte boundary (10'h2A5, 10'h15A) separate the two justifications from each other and from a swapped or shifted layout. The two's complement extremes and all-ones expose a truncated or sign-handled store. Read sequences place a conversion before, during, in the same cycle as and after a low-byte read, a high-byte read and a high-only read, which tells apart a hold that starts or ends one cycle late. A long random run then compares both bytes each cycle against a behavioural model.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int RES_W_DEF  = 10;
  localparam int BYTE_W_DEF = 8;

  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;
endpackage

// File: rtl/adc_read_lock.sv
module adc_read_lock (
  input  logic clk,
  input  logic rst,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic lock_q,
  output logic lock_next
);
  // high-byte read wins: a simultaneous pair read ends unlocked
  always_comb begin
    if (rd_hi)      lock_next = 1'b0;
    else if (rd_lo) lock_next = 1'b1;
    else            lock_next = lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_next;
  end

  p_lo_read_locks_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock_q);
  p_hi_read_frees_r7: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock_q);
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int RES_W = adc_res_pkg::RES_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_value,
  input  logic             lock_next,
  output logic [RES_W-1:0] res_q,
  output logic [RES_W-1:0] res_next
);
  logic take;

  assign take     = conv_done && !lock_next;
  assign res_next = take ? conv_value : res_q;

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_next;
  end
endmodule

// File: rtl/adc_byte_pack.sv
module adc_byte_pack #(
  parameter int RES_W  = adc_res_pkg::RES_W_DEF,
  parameter int BYTE_W = adc_res_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  res_next,
  input  logic              left_adj,
  output logic [BYTE_W-1:0] data_lo,
  output logic [BYTE_W-1:0] data_hi
);
  import adc_res_pkg::*;

  localparam int EXTRA = RES_W - BYTE_W;   // bits beyond one byte
  localparam int PAD   = BYTE_W - EXTRA;   // zero pad in left mode

  logic [BYTE_W-1:0] lo_r, hi_r, lo_l, hi_l;
  just_e mode_q;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bits
    assign lo_r[i] = res_next[i];
    assign hi_l[i] = res_next[EXTRA+i];
    if (i < EXTRA) begin : g_hi_used
      assign hi_r[i] = res_next[BYTE_W+i];
    end else begin : g_hi_pad
      assign hi_r[i] = 1'b0;
    end
    if (i >= PAD) begin : g_lo_used
      assign lo_l[i] = res_next[i-PAD];
    end else begin : g_lo_pad
      assign lo_l[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_lo <= '0;
      data_hi <= '0;
      mode_q  <= JUST_RIGHT;
    end else begin
      mode_q <= just_e'(left_adj);
      if (left_adj) begin
        data_lo <= lo_l;
        data_hi <= hi_l;
      end else begin
        data_lo <= lo_r;
        data_hi <= hi_r;
      end
    end
  end

  p_right_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == JUST_RIGHT) |-> (data_hi[BYTE_W-1:EXTRA] == '0));
  p_left_pad_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == JUST_LEFT) |-> (data_lo[PAD-1:0] == '0));
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W  = adc_res_pkg::RES_W_DEF,
  parameter int BYTE_W = adc_res_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              left_adj,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] data_lo,
  output logic [BYTE_W-1:0] data_hi
);
  logic             lock_q, lock_next;
  logic [RES_W-1:0] res_q, res_next;

  adc_read_lock u_lock (
    .clk       (clk),
    .rst       (rst),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .lock_q    (lock_q),
    .lock_next (lock_next)
  );

  adc_result_store #(.RES_W(RES_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .lock_next  (lock_next),
    .res_q      (res_q),
    .res_next   (res_next)
  );

  adc_byte_pack #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .res_next (res_next),
    .left_adj (left_adj),
    .data_lo  (data_lo),
    .data_hi  (data_hi)
  );

  p_hold_while_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !rd_hi) |=> $stable(res_q));
  p_same_cycle_lo_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> $stable(res_q));
  p_accept_free_r4: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !lock_q && !rd_lo) |=> (res_q == $past(conv_value)));
endmodule

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic       left_adj = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] data_lo, data_hi;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  // behavioural model state
  int m_res = 0;
  bit m_lock = 1'b0;
  bit m_adj = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_result_regs u_dut (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_value(conv_value),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .data_lo(data_lo), .data_hi(data_hi)
  );

  task automatic chk(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  function automatic int exp_hi();
    return m_adj ? (m_res >> 2) : (m_res >> 8);
  endfunction

  function automatic int exp_lo();
    return m_adj ? ((m_res & 3) << 6) : (m_res & 255);
  endfunction

  // one clock: model update at the edge, compare at the falling edge
  task automatic step();
    bit nl;
    @(posedge clk);
    cyc++;
    if (rst) begin
      m_res = 0; m_lock = 1'b0; m_adj = 1'b0;
    end else begin
      nl = rd_hi ? 1'b0 : (rd_lo ? 1'b1 : m_lock);
      if (conv_done && !nl) m_res = int'(conv_value);
      m_lock = nl;
      m_adj = left_adj;
    end
    @(negedge clk);
    chk({tag, " lo"}, int'(data_lo), exp_lo());
    chk({tag, " hi"}, int'(data_hi), exp_hi());
  endtask

  task automatic idle();
    conv_done = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic conv(input logic [9:0] v);
    conv_done = 1'b1; conv_value = v;
    step();
    idle();
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    tag = "R1"; rst = 1'b0;
    step();
    chk("R1 lo zero", int'(data_lo), 0);
    chk("R1 hi zero", int'(data_hi), 0);

    tag = "R4"; conv(10'h2A5);
    tag = "R2"; step();
    chk("R2 hi right", int'(data_hi), 'h02);
    chk("R2 lo right", int'(data_lo), 'hA5);

    tag = "R10"; left_adj = 1'b1; step();
    tag = "R3";
    chk("R3 hi left", int'(data_hi), 'hA9);
    chk("R3 lo left", int'(data_lo), 'h40);

    // R5: low read holds, later conversions dropped
    tag = "R5"; rd_lo = 1'b1; step(); idle();
    conv(10'h15A); conv(10'h0FF); step();
    chk("R5 held hi", int'(data_hi), 'hA9);
    // R10 while held
    tag = "R10"; left_adj = 1'b0; step();
    chk("R10 relaid lo", int'(data_lo), 'hA5);
    // R7: high read with same-cycle conversion accepted
    tag = "R7"; rd_hi = 1'b1; conv(10'h15A); step();
    chk("R7 accepted lo", int'(data_lo), 'h5A);

    // R6: conversion in the low-read cycle dropped
    tag = "R6"; rd_lo = 1'b1; conv(10'h3C3); step();
    chk("R6 dropped lo", int'(data_lo), 'h5A);
    rd_hi = 1'b1; step(); idle();

    // R8: high-only read in left mode leaves pair free
    tag = "R8"; left_adj = 1'b1; step();
    rd_hi = 1'b1; step(); idle();
    conv(10'h0C7); step();
    chk("R8 after hi-only", int'(data_hi), 'h31);

    // R9: two's complement extremes and all ones
    tag = "R9"; left_adj = 1'b0;
    conv(10'h200);
    chk("R9 min hi", int'(data_hi), 'h02);
    conv(10'h1FF);
    chk("R9 max lo", int'(data_lo), 'hFF);
    conv(10'h3FF);
    left_adj = 1'b1; step();
    chk("R9 ones left lo", int'(data_lo), 'hC0);

    // random traffic against the model
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      conv_done  = ($urandom_range(0, 2) == 0);
      conv_value = 10'($urandom);
      left_adj   = ($urandom_range(0, 15) == 0) ? ~left_adj : left_adj;
      rd_lo      = ($urandom_range(0, 5) == 0);
      rd_hi      = ($urandom_range(0, 6) == 0);
      step();
    end
    idle();
    step();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule